// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds several independent down-counters behind one register bus. Each channel has a control register, an interval register and a live count register. All channels share one interrupt-enable register and one status register. Software loads an interval and picks a prescale ratio. It then starts the channel in periodic mode, which reloads on every expiry, or in one-shot mode, which stops after the first expiry. Each expiry sets the channel's status bit, and the block drives one combined interrupt line.

The bus and its registers run on the bus clock. The counters run on a separate timer source clock. Enable, one-shot, prescale and reload requests cross into the timer domain through two-flop synchronizers. Expiry events and the acknowledgement of a reload come back the same way. The live count returns to the bus through a request/acknowledge snapshot, so a bus read never sees a value that is half updated.

The register bus is a plain single-cycle port with no back-pressure. A write takes effect at the bus clock edge where `bus_sel` and `bus_wr` are high. A read presents its data on `bus_rdata` one bus clock later. There is no valid/ready stream at the edge of this block, and nothing can stall.

Top module: `tmr_top`

## Requirements
- R1: The register map is as follows. Interrupt enable is at 0x00, with bit n gating channel n. Status is at 0x04, with bit n belonging to channel n. Channel n has control at 0x10+0x10·n, interval at 0x14+0x10·n and count at 0x18+0x10·n. Every register resets to 0. Read data appears one bus cycle after the read request. Unmapped addresses read 0, and writes to a count register are ignored.
- R2: The control fields are: bit 0 run enable, bit 1 reload request, bits 3:2 a source code that is stored and read back with no effect on counting, bits 6:4 the prescale exponent p, and bit 7 one-shot when 1 or periodic when 0.
- R3: A running channel decrements its count by one once every 2^p timer clock cycles, for p from 0 to 7.
- R4: When a tick finds the count at 0, the channel sets its status bit. After a load of interval N, the first expiry comes (N+1)·2^p timer cycles after the load, plus the synchronizer delay.
- R5: In one-shot mode an expiry stops the counter at 0, and hardware clears the channel's enable bit.
- R6: Setting the reload bit copies the interval into the counter once the request has reached the timer domain, whether or not the channel is enabled. Hardware then clears the reload bit.
- R7: In periodic mode each expiry reloads the interval, and counting continues, so expiries repeat every (N+1)·2^p timer cycles. With an interval of all ones the channel is a free-running down-counter.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: The interrupt output is high exactly when some channel has both its status bit and its enable bit set.
- R10: After enable is cleared, the counter keeps counting for at least two more timer cycles and then holds its value. Enabling again without a reload continues from the held value.
- R11: A count read returns a value that the counter really held: the value reads as decreasing over time and never torn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Active-low reset, bus domain |
| tclk | input | 1 | Timer source clock |
| trst_n | input | 1 | Active-low reset, timer domain |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data, one cycle after the request |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes and read-backs that stay in the bus domain are due one bus cycle after the request. The bench samples them on the falling edge that follows. Results that cross domains are not due at a single fixed cycle:
- An expiry appears in status about two to three bus cycles after the timer edge.
- A load waits three timer edges for synchronization.
- A count snapshot lags the counter by a few cycles of both clocks.

For these results the bench counts timer edges from the write and polls status on every other bus cycle. It accepts a window of a few cycles around (N+1)·2^p. Values that are meant to be frozen are checked only after a wait longer than any crossing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Per-channel control byte; bit positions are software-visible.
  typedef struct packed {
    logic       oneshot;  // 7
    logic [2:0] pres;     // 6:4
    logic [1:0] src;      // 3:2
    logic       reload;   // 1
    logic       en;       // 0
  } ctrl_t;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_IVAL = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [7:0] ADR_IEN  = 8'h00;
  localparam logic [7:0] ADR_STAT = 8'h04;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CW = 32,
  parameter int PW = 3
) (
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          en_s,
  input  logic          oneshot_s,
  input  logic [PW-1:0] pres_s,
  input  logic          ld_req_s,
  input  logic [CW-1:0] interval,
  input  logic          snap_req_s,
  output logic          ld_ack,
  output logic          exp_tgl,
  output logic          snap_ack,
  output logic [CW-1:0] snap
);
  localparam int DW = (1 << PW) - 1;

  logic [DW-1:0] psc, mask;
  logic [DW:0]   pow2;
  logic [CW-1:0] cnt;
  logic          halt, running, tick, load;

  assign pow2    = (DW+1)'(1) << pres_s;
  assign mask    = DW'(pow2 - 1'b1);
  assign tick    = (psc == mask);
  assign load    = ld_req_s && !ld_ack;
  assign running = en_s && !halt;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt <= '0; psc <= '0; halt <= 1'b0; exp_tgl <= 1'b0; ld_ack <= 1'b0;
    end else begin
      ld_ack <= ld_req_s;
      if (!en_s) halt <= 1'b0;
      if (load) begin
        cnt <= interval;
        psc <= '0;
      end else if (running) begin
        if (tick) begin
          psc <= '0;
          if (cnt == '0) begin
            exp_tgl <= ~exp_tgl;
            if (oneshot_s) halt <= 1'b1;
            else           cnt  <= interval;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          psc <= psc + 1'b1;
        end
      end else begin
        psc <= '0;
      end
    end
  end

  // Snapshot: captured only when a new request arrives, then held stable.
  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      snap <= '0; snap_ack <= 1'b0;
    end else if (snap_req_s != snap_ack) begin
      snap     <= cnt;
      snap_ack <= snap_req_s;
    end
  end

  p_count_step_r3: assert property (@(posedge tclk) disable iff (!trst_n)
    (running && tick && cnt != '0 && !load) |=> cnt == $past(cnt) - 1'b1);
  p_load_r6: assert property (@(posedge tclk) disable iff (!trst_n)
    load |=> cnt == $past(interval));
  p_oneshot_hold_r5: assert property (@(posedge tclk) disable iff (!trst_n)
    (halt && en_s && !load) |=> $stable(cnt));
  p_snap_hold_r11: assert property (@(posedge tclk) disable iff (!trst_n)
    (snap_req_s == snap_ack) |=> $stable(snap));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  localparam int HW = AW - 4;
  localparam int SW = 7;  // signals crossing into timer domain
  localparam int RW = 3;  // signals crossing back

  ctrl_t          ctrl  [NCH];
  logic [CW-1:0]  ival  [NCH];
  logic [CW-1:0]  shad  [NCH];
  logic [CW-1:0]  snap  [NCH];
  logic [NCH-1:0] ien, stat, snap_req, exp_d;
  logic [NCH-1:0] ld_ack_s, exp_s, snap_ack_s, exp_ev;
  logic [CW-1:0]  rd_mux;
  logic [HW-1:0]  hi;
  logic [3:0]     lo;
  logic           wr, rd;

  assign wr = bus_sel && bus_wr;
  assign rd = bus_sel && !bus_wr;
  assign hi = bus_addr[AW-1:4];
  assign lo = bus_addr[3:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SW-1:0] to_t, t_s;
    logic [RW-1:0] to_b, b_s;
    logic          t_ld_ack, t_exp, t_sack;

    assign to_t = {snap_req[g], ctrl[g].reload, ctrl[g].pres, ctrl[g].oneshot, ctrl[g].en};
    tmr_sync #(.W(SW)) u_to_t (.clk(tclk), .rst_n(trst_n), .d(to_t), .q(t_s));

    tmr_core #(.CW(CW), .PW(3)) u_core (
      .tclk(tclk), .trst_n(trst_n), .en_s(t_s[0]), .oneshot_s(t_s[1]),
      .pres_s(t_s[4:2]), .ld_req_s(t_s[5]), .interval(ival[g]),
      .snap_req_s(t_s[6]), .ld_ack(t_ld_ack), .exp_tgl(t_exp),
      .snap_ack(t_sack), .snap(snap[g]));

    assign to_b = {t_sack, t_exp, t_ld_ack};
    tmr_sync #(.W(RW)) u_to_b (.clk(bclk), .rst_n(brst_n), .d(to_b), .q(b_s));
    assign ld_ack_s[g]   = b_s[0];
    assign exp_s[g]      = b_s[1];
    assign snap_ack_s[g] = b_s[2];
    assign exp_ev[g]     = exp_s[g] ^ exp_d[g];

    p_w1c_r8: assert property (@(posedge bclk) disable iff (!brst_n)
      (wr && bus_addr == ADR_STAT && bus_wdata[g] && !exp_ev[g]) |=> !stat[g]);
    p_oneshot_off_r5: assert property (@(posedge bclk) disable iff (!brst_n)
      (exp_ev[g] && ctrl[g].oneshot && !(wr && hi == HW'(g+1) && lo == OFS_CTRL))
        |=> !ctrl[g].en);
    p_reload_ack_r6: assert property (@(posedge bclk) disable iff (!brst_n)
      ($fell(ctrl[g].reload) && !$past(wr && hi == HW'(g+1) && lo == OFS_CTRL))
        |-> $past(ld_ack_s[g]));
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      ien <= '0; stat <= '0; snap_req <= '0; exp_d <= '0; bus_rdata <= '0;
      for (int c = 0; c < NCH; c++) begin
        ctrl[c] <= '0; ival[c] <= '0; shad[c] <= '0;
      end
    end else begin
      exp_d <= exp_s;
      if (wr && bus_addr == ADR_IEN) ien <= bus_wdata[NCH-1:0];
      if (wr && bus_addr == ADR_STAT) stat <= (stat & ~bus_wdata[NCH-1:0]) | exp_ev;
      else                            stat <= stat | exp_ev;
      for (int c = 0; c < NCH; c++) begin
        if (ctrl[c].reload && ld_ack_s[c]) ctrl[c].reload <= 1'b0;
        if (exp_ev[c] && ctrl[c].oneshot)  ctrl[c].en     <= 1'b0;
        if (wr && hi == HW'(c+1) && lo == OFS_CTRL) ctrl[c] <= ctrl_t'(bus_wdata[7:0]);
        if (wr && hi == HW'(c+1) && lo == OFS_IVAL) ival[c] <= bus_wdata;
        if (snap_ack_s[c] == snap_req[c]) begin
          shad[c]     <= snap[c];
          snap_req[c] <= ~snap_req[c];
        end
      end
      if (rd) bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_IEN)  rd_mux[NCH-1:0] = ien;
    if (bus_addr == ADR_STAT) rd_mux[NCH-1:0] = stat;
    for (int c = 0; c < NCH; c++) begin
      if (hi == HW'(c+1)) begin
        case (lo)
          OFS_CTRL: rd_mux[7:0] = ctrl[c];
          OFS_IVAL: rd_mux      = ival[c];
          OFS_CNT:  rd_mux      = shad[c];
          default:  ;
        endcase
      end
    end
  end

  assign irq = |(stat & ien);
endmodule

// File: tb/sim_tmr_top.sv
`timescale 1ns/1ps
module sim_tmr_top;
  logic        bclk = 0, tclk = 0, brst_n = 0, trst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq;
  int checks = 0, fails = 0, tcyc = 0;
  bit done = 0;

  always #2 bclk = ~bclk;   // 250 MHz
  always #9 tclk = ~tclk;   // timer source
  always @(posedge tclk) tcyc <= tcyc + 1;

  tmr_top u0 (.bclk(bclk), .brst_n(brst_n), .tclk(tclk), .trst_n(trst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  typedef struct packed { logic [2:0] pres; logic [31:0] ival; logic oneshot; } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'd5, 1'b1}, '{3'd1, 32'd3, 1'b1}, '{3'd2, 32'd4, 1'b0},
    '{3'd3, 32'd2, 1'b1}, '{3'd0, 32'd0, 1'b1}, '{3'd0, 32'd9, 1'b0}};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%h expected=0x%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge bclk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge bclk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge bclk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge bclk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic twait(input int n);
    repeat (n) @(posedge tclk);
    @(negedge bclk);
  endtask

  task automatic poll(input int ch, output int t, output bit hit);
    logic [31:0] d;
    hit = 0;
    for (int k = 0; k < 20000 && !hit; k++) begin
      bread(8'h04, d);
      if (d[ch]) hit = 1;
    end
    t = tcyc;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0, ca, cb, cc;
    int t0, t1, t2, e;
    bit hit;
    repeat (4) @(posedge tclk);
    @(negedge bclk); brst_n = 1; trst_n = 1;
    twait(2);

    // R1 reset state
    check(irq == 0, "R1 irq after reset", 32'(irq), 0);
    foreach (VECS[i]) ; // keep table referenced
    bread(8'h00, d); check(d == 0, "R1 ien reset", d, 0);
    bread(8'h04, d); check(d == 0, "R1 status reset", d, 0);
    bread(8'h10, d); check(d == 0, "R1 ctrl0 reset", d, 0);
    bread(8'h24, d); check(d == 0, "R1 ival1 reset", d, 0);
    bread(8'h18, d); check(d == 0, "R1 count0 reset", d, 0);
    bread(8'h0C, d); check(d == 0, "R1 unmapped reads 0", d, 0);

    // R2 control field read-back, source code has no effect
    bwrite(8'h10, 32'hFC); bread(8'h10, d);
    check(d == 32'hFC, "R2 ctrl fields read back", d, 32'hFC);
    bwrite(8'h10, 32'h0);

    // R6 reload without enable
    bwrite(8'h14, 32'h1234); bwrite(8'h10, 32'h02); twait(20);
    bread(8'h18, d); check(d == 32'h1234, "R6 reload loads count", d, 32'h1234);
    bread(8'h10, d); check(d == 0, "R6 reload bit self-clears", d, 0);

    // Table of vectors: R3 R4 R5 R7 R8 R9
    bwrite(8'h00, 32'h3);
    for (int i = 0; i < NV; i++) begin
      logic [7:0] base = 8'h10 + 8'(16 * (i % 2));
      int ch = i % 2;
      e = (int'(VECS[i].ival) + 1) << VECS[i].pres;
      bwrite(base + 8'h4, VECS[i].ival);
      bwrite(base, {24'h0, VECS[i].oneshot, VECS[i].pres, 2'b00, 2'b11});
      t0 = tcyc;
      poll(ch, t1, hit);
      check(hit && (t1 - t0) >= e && (t1 - t0) <= e + 9, "R4 R3 first expiry time", 32'(t1 - t0), 32'(e));
      check(irq == 1, "R9 irq with status and enable", 32'(irq), 1);
      if (VECS[i].oneshot) begin
        twait(10);
        bread(base, d); check(d[1:0] == 0, "R5 one-shot clears enable", d, 0);
        bread(base + 8'h8, d); check(d == 0, "R5 one-shot holds zero", d, 0);
        bwrite(8'h04, 32'(1 << ch));
      end else begin
        bwrite(8'h04, 32'(1 << ch));
        bread(8'h04, d); check(d[ch] == 0, "R8 write one clears status", d, 0);
        poll(ch, t2, hit);
        check(hit && (t2 - t1) >= e - 2 && (t2 - t1) <= e + 2, "R7 periodic interval", 32'(t2 - t1), 32'(e));
        bread(base, d); check(d[0] == 1, "R7 periodic stays enabled", d, 1);
        bwrite(base, 32'h0); twait(8);
        bwrite(8'h04, 32'(1 << ch));
      end
      bread(8'h04, d); check(d == 0, "R8 status cleared", d, 0);
      check(irq == 0, "R9 irq low when clear", 32'(irq), 0);
    end

    // R9 gating and R8 write-zero
    bwrite(8'h00, 32'h0);
    bwrite(8'h14, 32'd3); bwrite(8'h10, 32'h83);
    poll(0, t1, hit); twait(4);
    check(irq == 0, "R9 masked status gives no irq", 32'(irq), 0);
    bwrite(8'h04, 32'h0); bread(8'h04, d);
    check(d[0] == 1, "R8 write zero keeps status", d, 1);
    bwrite(8'h04, 32'h1); bread(8'h04, d);
    check(d[0] == 0, "R8 write one clears", d, 0);

    // R7 free-run, R11 snapshot, R10 disable
    bwrite(8'h24, 32'hFFFF_FFFF); bwrite(8'h20, 32'h03); twait(30);
    bread(8'h28, c0);
    check(c0 < 32'hFFFF_FFF0 && c0 > 32'hFFFF_FF00, "R7 free-run near top", c0, 32'hFFFF_FFE0);
    twait(10); bread(8'h28, cb);
    check(cb < c0, "R11 count reads decreasing", cb, c0);
    bread(8'h28, c0);
    bwrite(8'h20, 32'h0); twait(20);
    bread(8'h28, ca); twait(40); bread(8'h28, cb);
    check(cb == ca, "R10 count frozen after disable", cb, ca);
    check(c0 - ca >= 2, "R10 counts on after disable", c0 - ca, 2);
    bwrite(8'h28, 32'h55); twait(10); bread(8'h28, d);
    check(d == ca, "R1 count write ignored", d, ca);
    bwrite(8'h20, 32'h01); twait(30); bread(8'h28, cc);
    check(cc < ca && cc > ca - 100, "R10 resume from held count", cc, ca);
    bwrite(8'h20, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule